// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This unit is the final stage of a single-precision floating-point datapath. An arithmetic stage in front of it produces an intermediate result: a sign, a signed unbiased exponent and a 27-bit significand. The significand holds the hidden bit at bit 26, the 23 fraction bits below it, and three extra low bits (guard, round, sticky) in bits 2..0. The unit turns that result into a packed 32-bit IEEE 754 word and reports overflow, underflow and inexact.

Values too small for the normal range are denormalised with a sticky right shift. If flush-to-zero is enabled they are instead replaced by a zero or a minimum subnormal, chosen by rounding direction and sign. Rounding supports nearest-even and the three directed modes. A carry out of the significand renormalises it. Exponents above the normal range saturate to infinity or to the largest finite value, depending on mode and sign. One case is handled on its own: at one step below the minimum exponent, a value that rounds up to the minimum normal is treated as not tiny.

The unit is a single register stage. A result presented with `in_valid` appears one cycle later with `out_valid`, and its flags come in the same cycle.

Top module: `sp_round_pack`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` is high. Result and flags are registered together. After reset, all outputs are zero.
- R2: The sign bit (bit 31) of every result equals the input sign, including zero, flushed and saturated results.
- R3: Rounding is applied only when the three low significand bits are nonzero, and that condition raises inexact. In mode 0 (nearest-even) the unit adds 3 plus bit 3, so an exact tie (low bits 100) rounds to even.
- R4: Mode 1 (toward zero) adds nothing. Mode 2 (toward +inf) adds 8 only when the sign is 0. Mode 3 (toward -inf) adds 8 only when the sign is 1.
- R5: If rounding carries past bit 26, the significand is shifted right by one and the exponent rises by one. At exponent +127 this overflows.
- R6: An exponent above +127 after rounding raises overflow and inexact. The result is an infinity (exponent field 0xFF, fraction 0) or the largest finite value (0xFE, all-ones fraction), with the sign kept:
  - mode 0 gives infinity;
  - mode 1 gives the largest finite value;
  - mode 2 gives +inf when positive and the largest finite value when negative;
  - mode 3 gives the largest finite value when positive and -inf when negative.
- R7: An exponent below -126 is right-shifted by (-126 − exponent), and all shifted-out bits are ORed into bit 0. If the low bits are then nonzero and the hidden bit is clear, underflow is raised. A result with the hidden bit clear is packed with exponent field 0.
- R8: At exponent -127, if rounding the unshifted significand carries past bit 26, the value is not tiny. The unit raises inexact only (no underflow) and produces the rounded value at exponent -126.
- R9: With flush-to-zero set, any exponent below -126 raises underflow and inexact. The result is a signed zero, except that it is the signed minimum subnormal (fraction 1) in mode 2 when positive and in mode 3 when negative.
- R10: With the underflow-trap enable set, a result whose exponent field is 0 raises underflow even when it is exact.
- R11: A normal result is packed with exponent field (exponent + 127) and the hidden bit removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Intermediate result present |
| in_sign | input | 1 | Sign of the intermediate result |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_sig | input | 27 | Hidden bit, 23 fraction bits, guard, round, sticky |
| in_rm | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| in_ftz | input | 1 | Flush tiny values to zero |
| in_uf_trap | input | 1 | Underflow trap enabled: exact tiny results also flag underflow |
| out_valid | output | 1 | Packed result present |
| res_word | output | 32 | Packed single-precision word |
| flag_ovf | output | 1 | Overflow |
| flag_unf | output | 1 | Underflow |
| flag_inx | output | 1 | Inexact |

## Verification
The assertions assume that `in_sig` always has bit 26 set and that the exponent fits in `EXP_W` signed bits. The flush and overflow properties rely on these assumptions. The bench only generates significands with the top bit forced to one, and exponents between -170 and +140. Directed vectors cover exact ties, a carry at +127, and exponents of -127 and -156. Random vectors mix all modes, both signs, flush-to-zero and the trap enable. A behavioural model in the bench checks every output on every cycle.

// File: rtl/sp_round_pack.sv
module sp_round_pack #(
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [26:0]             in_sig,
  input  logic [1:0]              in_rm,
  input  logic                    in_ftz,
  input  logic                    in_uf_trap,
  output logic                    out_valid,
  output logic [31:0]             res_word,
  output logic                    flag_ovf,
  output logic                    flag_unf,
  output logic                    flag_inx
);
  localparam int XW   = EXP_W + 2;
  localparam int EMIN = -126;
  localparam int EMAX = 127;
  localparam int BIAS = 127;
  localparam logic signed [XW-1:0] EMIN_X = XW'(EMIN);
  localparam logic signed [XW-1:0] EMAX_X = XW'(EMAX);

  function automatic logic [27:0] rnd(input logic [27:0] m, input logic s, input logic [1:0] mode);
    logic [27:0] inc;
    case (mode)
      2'd0:    inc = 28'd3 + {27'd0, m[3]};
      2'd1:    inc = 28'd0;
      2'd2:    inc = s ? 28'd0 : 28'd8;
      default: inc = s ? 28'd8 : 28'd0;
    endcase
    return (m[2:0] == 3'd0) ? m : m + inc;
  endfunction

  logic signed [XW-1:0] e0, es, e2;
  logic        tiny, not_tiny, grs, carry, ovf_c, unf_c, inx_c;
  logic [4:0]  sh;
  logic [27:0] wide, carry_m, shifted, m1, m2, m3;
  logic [23:0] frac;
  logic [31:0] word_c;

  assign e0       = XW'(in_exp);
  assign wide     = {1'b0, in_sig};
  assign tiny     = e0 < EMIN_X;
  assign es       = EMIN_X - e0;
  assign sh       = es[4:0];
  assign carry_m  = rnd(wide, in_sign, in_rm);
  assign not_tiny = tiny && (e0 == EMIN_X - XW'(1)) && carry_m[27];
  assign shifted  = (es >= XW'(27)) ? 28'd1
                  : (wide >> sh) | {27'd0, |(wide & ~({28{1'b1}} << sh))};

  assign m1    = not_tiny ? ((carry_m >> 1) & ~28'd7) : tiny ? shifted : wide;
  assign grs   = |m1[2:0];
  assign m2    = rnd(m1, in_sign, in_rm);
  assign carry = m2[27];
  assign m3    = carry ? (m2 >> 1) : m2;
  assign e2    = (tiny ? EMIN_X : e0) + XW'(carry);
  assign frac  = m3[26:3];

  always_comb begin
    ovf_c  = 1'b0;
    unf_c  = grs && !m1[26];
    inx_c  = grs || not_tiny;
    word_c = {in_sign, 31'd0};
    if (tiny && in_ftz) begin
      unf_c  = 1'b1;
      inx_c  = 1'b1;
      word_c = {in_sign, 30'd0, (in_rm == 2'd2 && !in_sign) || (in_rm == 2'd3 && in_sign)};
    end else if (e2 > EMAX_X) begin
      ovf_c = 1'b1;
      inx_c = 1'b1;
      if (in_rm == 2'd0 || (in_rm == 2'd2 && !in_sign) || (in_rm == 2'd3 && in_sign))
        word_c = {in_sign, 8'hFF, 23'd0};
      else
        word_c = {in_sign, 8'hFE, 23'h7FFFFF};
    end else if (!frac[23]) begin
      unf_c  = unf_c || in_uf_trap;
      word_c = {in_sign, 8'd0, frac[22:0]};
    end else begin
      word_c = {in_sign, 8'(e2 + XW'(BIAS)), frac[22:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_word  <= 32'd0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
      flag_inx  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_word <= word_c;
        flag_ovf <= ovf_c;
        flag_unf <= unf_c;
        flag_inx <= inx_c;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  p_idle_r1:    assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  p_sign_r2:    assert property (@(posedge clk) disable iff (!rst_n)
                  in_valid |=> res_word[31] == $past(in_sign));
  p_rz_finite_r4: assert property (@(posedge clk) disable iff (!rst_n)
                  in_valid && in_rm == 2'd1 |=> res_word[30:23] != 8'hFF);
  p_ovf_inx_r6: assert property (@(posedge clk) disable iff (!rst_n)
                  out_valid && flag_ovf |-> flag_inx);
  p_inf_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
                  out_valid && res_word[30:23] == 8'hFF |-> flag_ovf);
  p_ftz_r9:     assert property (@(posedge clk) disable iff (!rst_n)
                  in_valid && in_ftz && in_exp < EXP_W'(EMIN)
                  |=> flag_unf && flag_inx && res_word[30:23] == 8'd0 && res_word[22:1] == 22'd0);
  p_trap_r10:   assert property (@(posedge clk) disable iff (!rst_n)
                  in_valid && in_uf_trap |=> res_word[30:23] != 8'd0 || flag_unf);
endmodule

// File: tb/sp_round_pack_bench.sv
module sp_round_pack_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sign = 1'b0, in_ftz = 1'b0, in_uf_trap = 1'b0;
  logic signed [9:0] in_exp = '0;
  logic [26:0] in_sig = '0;
  logic [1:0] in_rm = '0;
  logic out_valid, flag_ovf, flag_unf, flag_inx;
  logic [31:0] res_word;

  int checks = 0, fails = 0;
  bit done = 0;
  bit prev_valid = 0;
  logic [34:0] prev_exp;
  string prev_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_round_pack #(.EXP_W(10)) u_sp_round_pack (
    .clk, .rst_n, .in_valid, .in_sign, .in_exp, .in_sig, .in_rm, .in_ftz, .in_uf_trap,
    .out_valid, .res_word, .flag_ovf, .flag_unf, .flag_inx);

  function automatic longint rnd_ref(longint m, bit s, int rm);
    if (m % 8 == 0) return m;
    case (rm)
      0: return m + 3 + ((m / 8) % 2);
      1: return m;
      2: return s ? m : m + 8;
      default: return s ? m + 8 : m;
    endcase
  endfunction

  function automatic logic [34:0] model(bit s, int e, longint m, int rm, bit ftz, bit trap);
    bit ovf = 0, unf = 0, inx = 0;
    logic [31:0] w;
    bit away = (rm == 2 && !s) || (rm == 3 && s);
    if (e < -126) begin
      if (ftz) return {1'b0, 1'b1, 1'b1, s, 30'd0, away};
      if (e == -127 && rnd_ref(m, s, rm) >= 64'd134217728) begin
        inx = 1;
        m = (rnd_ref(m, s, rm) / 2) / 8 * 8;
        e = -126;
      end else begin
        while (e < -126) begin
          m = (m >> 1) | (m & 1);
          e++;
        end
      end
    end
    if (m % 8 != 0) begin
      inx = 1;
      if (m < 64'd67108864) unf = 1;
      m = rnd_ref(m, s, rm);
      if (m >= 64'd134217728) begin
        m = m / 2;
        e++;
      end
    end
    m = m / 8;
    if (e > 127) begin
      ovf = 1; inx = 1;
      if (rm == 0 || away) w = {s, 8'hFF, 23'd0};
      else w = {s, 8'hFE, 23'h7FFFFF};
    end else if (m < 64'd8388608) begin
      if (trap) unf = 1;
      w = {s, 8'd0, 23'(m)};
    end else begin
      w = {s, 8'(e + 127), 23'(m - 64'd8388608)};
    end
    return {ovf, unf, inx, w};
  endfunction

  task automatic check_prev();
    checks++;
    if (out_valid !== prev_valid) begin
      fails++;
      $display("FAIL %s out_valid actual %b expected %b", prev_tag, out_valid, prev_valid);
    end
    if (prev_valid) begin
      checks++;
      if ({flag_ovf, flag_unf, flag_inx, res_word} !== prev_exp) begin
        fails++;
        $display("FAIL %s ovf/unf/inx/word actual %b%b%b %h expected %b %h", prev_tag,
                 flag_ovf, flag_unf, flag_inx, res_word, prev_exp[34:32], prev_exp[31:0]);
      end
    end
  endtask

  task automatic step(bit v, bit s, int e, logic [26:0] sig, int rm, bit ftz, bit trap, string tag);
    @(negedge clk);
    check_prev();
    in_valid = v; in_sign = s; in_exp = 10'(e); in_sig = sig;
    in_rm = 2'(rm); in_ftz = ftz; in_uf_trap = trap;
    prev_valid = v;
    prev_tag = tag;
    if (v) prev_exp = model(s, e, longint'(sig), rm, ftz, trap);
  endtask

  localparam logic [26:0] ONE  = 27'h4000000;
  localparam logic [26:0] ALL1 = 27'h7FFFFFF;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || res_word !== 32'd0 || {flag_ovf, flag_unf, flag_inx} !== 3'b000) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b %h expected 0 00000000", out_valid, res_word);
    end
    rst_n = 1'b1;
    step(1, 0, 0, ONE, 0, 0, 0, "R11");
    step(1, 1, -20, ONE | 27'h12340, 0, 0, 0, "R11");
    step(1, 0, 0, ONE | 27'd4, 0, 0, 0, "R3");
    step(1, 0, 0, ONE | 27'd12, 0, 0, 0, "R3");
    step(1, 1, 3, ONE | 27'd5, 0, 0, 0, "R3");
    step(0, 0, 0, ONE, 0, 0, 0, "R1");
    step(1, 0, 1, ONE | 27'd3, 1, 0, 0, "R4");
    step(1, 0, 1, ONE | 27'd1, 2, 0, 0, "R4");
    step(1, 1, 1, ONE | 27'd1, 2, 0, 0, "R4");
    step(1, 0, 1, ONE | 27'd1, 3, 0, 0, "R4");
    step(1, 1, 1, ONE | 27'd1, 3, 0, 0, "R4");
    step(1, 0, 5, ALL1, 0, 0, 0, "R5");
    step(1, 0, 127, ALL1, 0, 0, 0, "R5");
    step(1, 1, 127, ALL1, 1, 0, 0, "R5");
    for (int rm = 0; rm < 4; rm++) begin
      step(1, 0, 128, ONE, rm, 0, 0, "R6");
      step(1, 1, 128, ONE, rm, 0, 0, "R6");
    end
    step(1, 0, -127, ALL1, 0, 0, 0, "R8");
    step(1, 1, -127, ALL1, 3, 0, 0, "R8");
    step(1, 0, -127, ALL1, 1, 0, 0, "R7");
    step(1, 0, -156, ONE, 0, 0, 0, "R7");
    step(1, 0, -156, ONE, 2, 0, 0, "R7");
    step(1, 1, -300, ONE | 27'd7, 3, 0, 0, "R7");
    step(1, 0, -130, ONE, 0, 0, 0, "R7");
    step(1, 0, -130, ONE, 0, 0, 1, "R10");
    step(1, 1, -156, ONE, 1, 0, 1, "R10");
    for (int rm = 0; rm < 4; rm++) begin
      step(1, 0, -127, ALL1, rm, 1, 0, "R9");
      step(1, 1, -140, ONE, rm, 1, 0, "R9");
    end
    step(1, 1, -5, ONE, 0, 0, 0, "R2");
    for (int i = 0; i < 3000; i++) begin
      logic [26:0] sig;
      int e;
      sig = {1'b1, 26'($urandom)};
      if ($urandom_range(0, 3) == 0) sig[2:0] = 3'b100;
      if ($urandom_range(0, 7) == 0) sig[26:3] = 24'hFFFFFF;
      e = int'($urandom_range(0, 310)) - 170;
      step($urandom_range(0, 9) != 0, 1'($urandom), e, sig, int'($urandom_range(0, 3)),
           $urandom_range(0, 7) == 0, 1'($urandom), "R2");
    end
    step(0, 0, 0, ONE, 0, 0, 0, "R1");
    step(0, 0, 0, ONE, 0, 0, 0, "R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog run did not end expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule